// File: doc/BRIEF.md
# Address Translation Control with Split-Mode Translation Buffers

This block sits between a processor's address path and an external page-table walker. It holds four 32-bit control registers and two direct-mapped translation buffers, one for user-mode accesses and one for supervisor-mode accesses. On every access it looks up the buffer for the access mode and does one of four things. It returns a physical address, signals a write-protection fault, or requests a table walk. For a purge store, it removes the matching translation from both buffers. When translation is switched off for the access mode, the virtual address passes straight through.

Software manages the buffers mostly through side effects. Reading the buffer-control register clears both buffers. Writing chosen values to that register clears one buffer. Rewriting a segment-table pointer clears the buffer for its mode. A store in the purge address space removes one translation. The status register holds the translation enables, a few plain control bits, and fault flags. The hardware sets those flags and only software clears them.

Top module: `mmu_xlate_ctl`

## Requirements
- R1: After reset both buffers are empty, both pointers read 0, the status register reads 0, and so translation is off for both modes.
- R2: Registers are selected by the longword-aligned byte offset: 0x0 supervisor segment pointer, 0x4 user segment pointer, 0x8 buffer control, 0xC status. A pointer stores write-data bits 19:0 and reads them back zero-extended. An access whose offset bits 1:0 are not zero has no effect.
- R3: When the enable bit for the access mode is clear (status bit 0 user, bit 1 supervisor), the access completes as a hit with the physical address equal to the virtual address and no walk request.
- R4: With translation enabled, an access with no valid entry raises the walk request. A fill with PTE bit 0 set stores the entry. A later hit returns {PTE[31:12], VA[11:0]}, with cache-inhibit equal to PTE bit 6. A fill with PTE bit 0 clear stores nothing.
- R5: Each buffer is direct-mapped with index VA[21:12] and tag VA[31:22]. An access with a different tag at the same index misses, and a fill replaces the entry at its index.
- R6: User and supervisor translations are held separately, so an entry filled for one mode never hits an access in the other mode.
- R7: A longword read at offset 0x8 returns 0 and empties both buffers.
- R8: Writing 0 at offset 0x8 empties only the user buffer. Writing 0x8000 there empties only the supervisor buffer. Any other value written there changes nothing.
- R9: Writing the user pointer empties the user buffer, and writing the supervisor pointer empties the supervisor buffer.
- R10: A store with function code 3 raises the purge output, reports no hit, miss or fault, and invalidates the entry for that VA in both buffers when its tag matches. Entries with a different tag stay.
- R11: A write that hits an entry with PTE bit 2 (read-only) set raises the protection fault and sets status bits 13 and 3. A write that hits an entry with PTE bit 4 (modified) clear raises the walk request instead.
- R12: The walker fault inputs set status bit 15 (page table) or bit 14 (page), each together with bit 3. Bits 15, 14, 13 and 3 stay set until software writes the status register, which loads them from the written data. Bits 0, 1, 2, 5 and 6 are plain read/write, and all other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| acc_valid | input | 1 | Access present this cycle |
| acc_super | input | 1 | Access is in supervisor mode |
| acc_write | input | 1 | Access is a store |
| acc_fc | input | 3 | Function code of the access |
| acc_va | input | 32 | Virtual address |
| acc_pa | output | 32 | Translated physical address |
| acc_hit | output | 1 | Translation available |
| acc_miss | output | 1 | Walk request |
| acc_cinh | output | 1 | Cache inhibit for the hit page |
| acc_prot_fault | output | 1 | Write to a read-only page |
| acc_purge | output | 1 | Purge store absorbed, no memory write |
| fill_valid | input | 1 | Walker delivers a page-table entry |
| fill_super | input | 1 | Fill targets the supervisor buffer |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pte | input | 32 | Page-table entry for the fill |
| walk_pt_fault | input | 1 | Walker hit an invalid segment entry |
| walk_pg_fault | input | 1 | Walker hit an invalid page entry |

## Verification
The assertions assume that reset is held for at least one rising edge. They also assume the walker fault inputs are single-cycle pulses and that a purge is signalled only on a store with function code 3. The scoreboard changes every input just after a rising edge and holds it for a whole cycle, so at most one register strobe, one access and one fill are present in any cycle. Fills are issued only in cycles without an access, so each lookup sees the buffer state left by the previous edge, and each expected result follows from the order of the stimulus alone.

// File: rtl/mmu_pkg.sv
// Shared constants for the address translation control block.
// Assumes 32-bit registers; bit positions here are decoded by software
// and by the walker, so they are fixed rather than parameters.
package mmu_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_SPTR = 2'd0,
        SEL_UPTR = 2'd1,
        SEL_TCTL = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    // status register bit positions
    localparam int ST_UEN  = 0;
    localparam int ST_SEN  = 1;
    localparam int ST_CEN  = 2;
    localparam int ST_BERR = 3;
    localparam int ST_ICEN = 5;
    localparam int ST_FPEN = 6;
    localparam int ST_PROT = 13;
    localparam int ST_PG   = 14;
    localparam int ST_PT   = 15;

    // page-table entry bit positions
    localparam int PTE_V   = 0;
    localparam int PTE_RO  = 2;
    localparam int PTE_MOD = 4;
    localparam int PTE_CI  = 6;

    localparam logic [2:0] FC_PURGE = 3'd3;

    localparam logic [REG_W-1:0] TCTL_FLUSH_USER  = 32'h0000_0000;
    localparam logic [REG_W-1:0] TCTL_FLUSH_SUPER = 32'h0000_8000;

endpackage

// File: rtl/mmu_tlb_bank.sv
// One direct-mapped translation buffer.
// Lookup and purge-match are combinational on the current contents;
// fill, purge and flush take effect at the next rising edge.
// Assumes the caller never needs the entry payload once the valid bit is
// clear, so the payload array carries no reset.
module mmu_tlb_bank #(
    parameter int VA_W  = 32,
    parameter int PG_W  = 12,
    parameter int IDX_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [VA_W-PG_W-1:0]   look_vpn,
    output logic                   look_hit,
    output logic [VA_W-PG_W-1:0]   look_pfn,
    output logic                   look_ro,
    output logic                   look_ci,
    output logic                   look_md,
    input  logic                   fill_en,
    input  logic [VA_W-PG_W-1:0]   fill_vpn,
    input  logic [VA_W-PG_W-1:0]   fill_pfn,
    input  logic                   fill_ro,
    input  logic                   fill_ci,
    input  logic                   fill_md,
    input  logic                   purge_en,
    input  logic [VA_W-PG_W-1:0]   purge_vpn,
    input  logic                   flush_all
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int VPN_W = VA_W - PG_W;
    localparam int TAG_W = VPN_W - IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [VPN_W-1:0] pfn;
        logic             ro;
        logic             ci;
        logic             md;
    } ent_t;

    ent_t             mem [DEPTH];
    logic [DEPTH-1:0] vld;

    logic [IDX_W-1:0] l_idx, f_idx, p_idx;
    ent_t             l_ent, p_ent;
    logic             purge_match;

    assign l_idx = look_vpn[IDX_W-1:0];
    assign f_idx = fill_vpn[IDX_W-1:0];
    assign p_idx = purge_vpn[IDX_W-1:0];
    assign l_ent = mem[l_idx];
    assign p_ent = mem[p_idx];

    // lookup: hit when the indexed entry is valid and its tag matches
    always_comb begin
        look_hit = vld[l_idx] && (l_ent.tag == look_vpn[VPN_W-1:IDX_W]);
        look_pfn = l_ent.pfn;
        look_ro  = l_ent.ro;
        look_ci  = l_ent.ci;
        look_md  = l_ent.md;
    end

    // purge only removes the entry whose tag belongs to the purged VA
    assign purge_match = purge_en && vld[p_idx]
                         && (p_ent.tag == purge_vpn[VPN_W-1:IDX_W]);

    // payload write on fill
    always_ff @(posedge clk) begin
        if (fill_en) begin
            mem[f_idx] <= '{tag: fill_vpn[VPN_W-1:IDX_W], pfn: fill_pfn,
                            ro: fill_ro, ci: fill_ci, md: fill_md};
        end
    end

    // valid bits: flush beats purge beats fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (flush_all) begin
            vld <= '0;
        end else begin
            if (fill_en)     vld[f_idx] <= 1'b1;
            if (purge_match) vld[p_idx] <= 1'b0;
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld == '0)); // R7

    AST_FILL_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !purge_en) |=> vld[$past(f_idx)]); // R4

    AST_PURGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        purge_match |=> !vld[$past(p_idx)]); // R10

endmodule

// File: rtl/mmu_regs.sv
// Control registers: two segment pointers, the buffer-control strobe
// register and the status register with sticky fault flags.
// Assumes strobes arrive already qualified for longword alignment.
// Flush requests are combinational and act at the same rising edge.
module mmu_regs
    import mmu_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             set_pt,
    input  logic             set_pg,
    input  logic             set_prot,
    output logic             user_en,
    output logic             super_en,
    output logic             flush_user,
    output logic             flush_super
);

    logic [PTR_W-1:0] sptr, uptr;
    logic             cen, icen, fpen;
    logic             st_pt, st_pg, st_prot, st_berr;
    logic             any_set;
    logic             stat_wr;

    assign any_set = set_pt || set_pg || set_prot;
    assign stat_wr = wr_en && (sel == SEL_STAT);

    // flush requests from pointer rewrites and buffer-control accesses
    always_comb begin
        flush_user  = (wr_en && (sel == SEL_UPTR))
                    || (wr_en && (sel == SEL_TCTL) && (wdata == TCTL_FLUSH_USER))
                    || (rd_en && (sel == SEL_TCTL));
        flush_super = (wr_en && (sel == SEL_SPTR))
                    || (wr_en && (sel == SEL_TCTL) && (wdata == TCTL_FLUSH_SUPER))
                    || (rd_en && (sel == SEL_TCTL));
    end

    // segment pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sptr <= '0;
            uptr <= '0;
        end else if (wr_en) begin
            if (sel == SEL_SPTR) sptr <= wdata[PTR_W-1:0];
            if (sel == SEL_UPTR) uptr <= wdata[PTR_W-1:0];
        end
    end

    // plain status control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_en  <= 1'b0;
            super_en <= 1'b0;
            cen      <= 1'b0;
            icen     <= 1'b0;
            fpen     <= 1'b0;
        end else if (stat_wr) begin
            user_en  <= wdata[ST_UEN];
            super_en <= wdata[ST_SEN];
            cen      <= wdata[ST_CEN];
            icen     <= wdata[ST_ICEN];
            fpen     <= wdata[ST_FPEN];
        end
    end

    // sticky fault flags: hardware only sets, software write reloads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_pt   <= 1'b0;
            st_pg   <= 1'b0;
            st_prot <= 1'b0;
            st_berr <= 1'b0;
        end else if (stat_wr) begin
            st_pt   <= wdata[ST_PT]   | set_pt;
            st_pg   <= wdata[ST_PG]   | set_pg;
            st_prot <= wdata[ST_PROT] | set_prot;
            st_berr <= wdata[ST_BERR] | any_set;
        end else begin
            st_pt   <= st_pt   | set_pt;
            st_pg   <= st_pg   | set_pg;
            st_prot <= st_prot | set_prot;
            st_berr <= st_berr | any_set;
        end
    end

    // read data mux
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_SPTR: rdata[PTR_W-1:0] = sptr;
            SEL_UPTR: rdata[PTR_W-1:0] = uptr;
            SEL_TCTL: rdata = '0;
            SEL_STAT: begin
                rdata[ST_UEN]  = user_en;
                rdata[ST_SEN]  = super_en;
                rdata[ST_CEN]  = cen;
                rdata[ST_BERR] = st_berr;
                rdata[ST_ICEN] = icen;
                rdata[ST_FPEN] = fpen;
                rdata[ST_PROT] = st_prot;
                rdata[ST_PG]   = st_pg;
                rdata[ST_PT]   = st_pt;
            end
            default: rdata = '0;
        endcase
    end

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_pt || st_pg) && !stat_wr) |=> (st_pt || st_pg)); // R12

    AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        set_pg |=> (st_pg && st_berr)); // R12

    AST_PROT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        set_prot |=> (st_prot && st_berr)); // R11

endmodule

// File: rtl/mmu_xlate_ctl.sv
// Address translation control: register file plus one buffer per mode.
// Each access is resolved combinationally in its own cycle into exactly
// one of hit, walk request, protection fault or purge.
// Assumes fills come from an external walker and never coincide with
// an access that depends on them.
module mmu_xlate_ctl
    import mmu_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PG_W  = 12,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             acc_valid,
    input  logic             acc_super,
    input  logic             acc_write,
    input  logic [2:0]       acc_fc,
    input  logic [VA_W-1:0]  acc_va,
    output logic [VA_W-1:0]  acc_pa,
    output logic             acc_hit,
    output logic             acc_miss,
    output logic             acc_cinh,
    output logic             acc_prot_fault,
    output logic             acc_purge,
    input  logic             fill_valid,
    input  logic             fill_super,
    input  logic [VA_W-PG_W-1:0] fill_vpn,
    input  logic [VA_W-1:0]  fill_pte,
    input  logic             walk_pt_fault,
    input  logic             walk_pg_fault
);

    localparam int VPN_W   = VA_W - PG_W;
    localparam int N_MODES = 2;

    logic             aligned, wr_ok, rd_ok;
    logic             user_en, super_en, flush_user, flush_super;
    logic             mode_en, purge;
    logic             pte_unused;
    logic [VPN_W-1:0] acc_vpn;

    logic             b_hit   [N_MODES];
    logic [VPN_W-1:0] b_pfn   [N_MODES];
    logic             b_ro    [N_MODES];
    logic             b_ci    [N_MODES];
    logic             b_md    [N_MODES];
    logic             b_fill  [N_MODES];
    logic             b_flush [N_MODES];

    assign aligned    = (reg_addr[1:0] == 2'b00);
    assign wr_ok      = reg_wr && aligned;
    assign rd_ok      = reg_rd && aligned;
    assign acc_vpn    = acc_va[VA_W-1:PG_W];
    assign purge      = acc_valid && acc_write && (acc_fc == FC_PURGE);
    assign mode_en    = acc_super ? super_en : user_en;
    assign pte_unused = ^{fill_pte[PG_W-1:PTE_CI+1], fill_pte[PTE_CI-1],
                          fill_pte[PTE_MOD-1], fill_pte[PTE_RO-1]};

    mmu_regs #(.PTR_W(VPN_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_ok),
        .rd_en       (rd_ok),
        .sel         (reg_sel_e'(reg_addr[3:2])),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .set_pt      (walk_pt_fault),
        .set_pg      (walk_pg_fault),
        .set_prot    (acc_prot_fault),
        .user_en     (user_en),
        .super_en    (super_en),
        .flush_user  (flush_user),
        .flush_super (flush_super)
    );

    // one buffer per mode: index 0 user, index 1 supervisor
    for (genvar m = 0; m < N_MODES; m++) begin : g_bank
        assign b_fill[m]  = fill_valid && (fill_super == (m == 1))
                            && fill_pte[PTE_V];
        assign b_flush[m] = (m == 0) ? flush_user : flush_super;

        mmu_tlb_bank #(.VA_W(VA_W), .PG_W(PG_W), .IDX_W(IDX_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .look_vpn  (acc_vpn),
            .look_hit  (b_hit[m]),
            .look_pfn  (b_pfn[m]),
            .look_ro   (b_ro[m]),
            .look_ci   (b_ci[m]),
            .look_md   (b_md[m]),
            .fill_en   (b_fill[m]),
            .fill_vpn  (fill_vpn),
            .fill_pfn  (fill_pte[VA_W-1:PG_W]),
            .fill_ro   (fill_pte[PTE_RO]),
            .fill_ci   (fill_pte[PTE_CI]),
            .fill_md   (fill_pte[PTE_MOD]),
            .purge_en  (purge),
            .purge_vpn (acc_vpn),
            .flush_all (b_flush[m])
        );
    end

    // resolve the access into a single outcome
    always_comb begin
        acc_pa         = acc_va;
        acc_hit        = 1'b0;
        acc_miss       = 1'b0;
        acc_cinh       = 1'b0;
        acc_prot_fault = 1'b0;
        acc_purge      = purge;
        if (acc_valid && !purge) begin
            if (!mode_en) begin
                acc_hit = 1'b1;
            end else if (!b_hit[acc_super]) begin
                acc_miss = 1'b1;
            end else if (acc_write && b_ro[acc_super]) begin
                acc_prot_fault = 1'b1;
            end else if (acc_write && !b_md[acc_super]) begin
                acc_miss = 1'b1;
            end else begin
                acc_hit  = 1'b1;
                acc_pa   = {b_pfn[acc_super], acc_va[PG_W-1:0]};
                acc_cinh = b_ci[acc_super];
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_hit, acc_miss, acc_prot_fault, acc_purge})); // R4

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !purge && !mode_en) |-> (acc_hit && acc_pa == acc_va)); // R3

    AST_PURGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_purge |-> (!acc_hit && !acc_miss && !acc_prot_fault)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(acc_hit || acc_miss || acc_prot_fault || acc_purge)); // R4

endmodule

// File: tb/tb_mmu_xlate_ctl.sv
// Scoreboard bench: driver tasks apply one operation per cycle just after
// the rising edge and queue the expected outcome; the monitor compares at
// the falling edge of the same cycle.
module tb_mmu_xlate_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        acc_valid, acc_super, acc_write;
    logic [2:0]  acc_fc;
    logic [31:0] acc_va, acc_pa;
    logic        acc_hit, acc_miss, acc_cinh, acc_prot_fault, acc_purge;
    logic        fill_valid, fill_super;
    logic [19:0] fill_vpn;
    logic [31:0] fill_pte;
    logic        walk_pt_fault, walk_pg_fault;

    typedef struct {
        bit          is_reg;
        string       req;
        logic [31:0] pa;
        logic        hit, miss, prot, purge, cinh;
        logic [31:0] rdata;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_xlate_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_super(acc_super), .acc_write(acc_write),
        .acc_fc(acc_fc), .acc_va(acc_va), .acc_pa(acc_pa),
        .acc_hit(acc_hit), .acc_miss(acc_miss), .acc_cinh(acc_cinh),
        .acc_prot_fault(acc_prot_fault), .acc_purge(acc_purge),
        .fill_valid(fill_valid), .fill_super(fill_super),
        .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .walk_pt_fault(walk_pt_fault), .walk_pg_fault(walk_pg_fault)
    );

    task automatic clear_inputs();
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        acc_valid = 0; acc_super = 0; acc_write = 0; acc_fc = 3'd1; acc_va = '0;
        fill_valid = 0; fill_super = 0; fill_vpn = '0; fill_pte = '0;
        walk_pt_fault = 0; walk_pg_fault = 0;
    endtask

    task automatic next_slot();
        @(posedge clk);
        #1;
        clear_inputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) next_slot();
    endtask

    task automatic acc(input bit sup, input bit wr, input logic [2:0] fc,
                       input logic [31:0] va, input bit e_hit, input bit e_miss,
                       input bit e_prot, input bit e_purge, input logic [31:0] e_pa,
                       input bit e_ci, input string req);
        exp_t e;
        next_slot();
        acc_valid = 1; acc_super = sup; acc_write = wr; acc_fc = fc; acc_va = va;
        e.is_reg = 0; e.req = req; e.pa = e_pa; e.hit = e_hit; e.miss = e_miss;
        e.prot = e_prot; e.purge = e_purge; e.cinh = e_ci; e.rdata = '0;
        q.push_back(e);
    endtask

    task automatic rd_hit(input bit sup, input logic [31:0] va,
                          input logic [31:0] pa, input bit ci, input string req);
        acc(sup, 0, 3'd1, va, 1, 0, 0, 0, pa, ci, req);
    endtask

    task automatic rd_miss(input bit sup, input logic [31:0] va, input string req);
        acc(sup, 0, 3'd1, va, 0, 1, 0, 0, va, 0, req);
    endtask

    task automatic fill(input bit sup, input logic [31:0] va, input logic [31:0] pte);
        next_slot();
        fill_valid = 1; fill_super = sup; fill_vpn = va[31:12]; fill_pte = pte;
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        next_slot();
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic reg_read(input logic [3:0] a, input logic [31:0] exp_d,
                            input string req);
        exp_t e;
        next_slot();
        reg_rd = 1; reg_addr = a;
        e.is_reg = 1; e.req = req; e.rdata = exp_d; e.pa = '0;
        e.hit = 0; e.miss = 0; e.prot = 0; e.purge = 0; e.cinh = 0;
        q.push_back(e);
    endtask

    task automatic walk_fault(input bit pt, input bit pg);
        next_slot();
        walk_pt_fault = pt; walk_pg_fault = pg;
    endtask

    // monitor: compare outputs mid-cycle against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (e.is_reg) begin
                    if (reg_rdata !== e.rdata) begin
                        errors++;
                        $display("FAIL %s rdata actual %h expected %h",
                                 e.req, reg_rdata, e.rdata);
                    end
                end else if (acc_hit !== e.hit || acc_miss !== e.miss ||
                             acc_prot_fault !== e.prot || acc_purge !== e.purge ||
                             acc_pa !== e.pa || acc_cinh !== e.cinh) begin
                    errors++;
                    $display("FAIL %s actual hit%b miss%b prot%b purge%b ci%b pa %h expected hit%b miss%b prot%b purge%b ci%b pa %h",
                             e.req, acc_hit, acc_miss, acc_prot_fault, acc_purge,
                             acc_cinh, acc_pa, e.hit, e.miss, e.prot, e.purge,
                             e.cinh, e.pa);
                end
            end
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        reg_read(4'hC, 32'h0, "R1");
        reg_read(4'h0, 32'h0, "R1");
        reg_read(4'h4, 32'h0, "R1");

        // R3 translation off: pass-through
        rd_hit(0, 32'h1234_5678, 32'h1234_5678, 0, "R3");
        acc(1, 1, 3'd5, 32'hCAFE_0010, 1, 0, 0, 0, 32'hCAFE_0010, 0, "R3");

        // R12 plain and sticky status bits
        reg_write(4'hC, 32'hFFFF_FFFF);
        reg_read(4'hC, 32'h0000_E06F, "R12");
        reg_write(4'hC, 32'h0000_0003);
        reg_read(4'hC, 32'h0000_0003, "R12");

        // R2 pointers and misaligned offsets
        reg_write(4'h0, 32'hABCD_E123);
        reg_read(4'h0, 32'h000D_E123, "R2");
        reg_write(4'h4, 32'h0005_5555);
        reg_read(4'h4, 32'h0005_5555, "R2");
        reg_write(4'h5, 32'h0001_2345);
        reg_read(4'h4, 32'h0005_5555, "R2");

        // R4 miss, fill, hit; fill with invalid PTE is dropped
        rd_miss(0, 32'h0040_3ABC, "R4");
        fill(0, 32'h0040_3000, 32'h7777_7051);
        rd_hit(0, 32'h0040_3ABC, 32'h7777_7ABC, 1, "R4");
        fill(0, 32'h0080_5000, 32'h1111_1010);
        rd_miss(0, 32'h0080_5000, "R4");

        // R5 same index, different tag
        rd_miss(0, 32'h0080_3ABC, "R5");
        fill(0, 32'h0080_3000, 32'h2222_2011);
        rd_hit(0, 32'h0080_3ABC, 32'h2222_2ABC, 0, "R5");
        rd_miss(0, 32'h0040_3ABC, "R5");

        // R6 modes are separate
        rd_miss(1, 32'h0080_3ABC, "R6");
        fill(1, 32'h0080_3000, 32'h3333_3011);
        rd_hit(1, 32'h0080_3ABC, 32'h3333_3ABC, 0, "R6");
        rd_hit(0, 32'h0080_3ABC, 32'h2222_2ABC, 0, "R6");

        // R11 write protection and modified-bit handling
        acc(0, 1, 3'd1, 32'h0080_3ABC, 1, 0, 0, 0, 32'h2222_2ABC, 0, "R11");
        fill(0, 32'h00C0_1000, 32'h4444_4015);
        acc(0, 1, 3'd1, 32'h00C0_1234, 0, 0, 1, 0, 32'h00C0_1234, 0, "R11");
        rd_hit(0, 32'h00C0_1234, 32'h4444_4234, 0, "R11");
        reg_read(4'hC, 32'h0000_200B, "R11");
        fill(0, 32'h0100_2000, 32'h5555_5001);
        acc(0, 1, 3'd1, 32'h0100_2008, 0, 1, 0, 0, 32'h0100_2008, 0, "R11");
        rd_hit(0, 32'h0100_2008, 32'h5555_5008, 0, "R11");

        // R12 walker faults are sticky until a status write
        walk_fault(1, 0);
        reg_read(4'hC, 32'h0000_A00B, "R12");
        walk_fault(0, 1);
        idle(3);
        reg_read(4'hC, 32'h0000_E00B, "R12");
        reg_write(4'hC, 32'h0000_0003);
        reg_read(4'hC, 32'h0000_0003, "R12");

        // R10 purge store
        acc(0, 1, 3'd3, 32'h0080_3ABC, 0, 0, 0, 1, 32'h0080_3ABC, 0, "R10");
        rd_miss(0, 32'h0080_3ABC, "R10");
        rd_miss(1, 32'h0080_3ABC, "R10");
        acc(1, 1, 3'd3, 32'h0040_1000, 0, 0, 0, 1, 32'h0040_1000, 0, "R10");
        rd_hit(0, 32'h00C0_1234, 32'h4444_4234, 0, "R10");

        // R8 buffer-control writes
        fill(1, 32'h0080_3000, 32'h3333_3011);
        reg_write(4'h8, 32'h0000_1234);
        rd_hit(0, 32'h00C0_1234, 32'h4444_4234, 0, "R8");
        rd_hit(1, 32'h0080_3ABC, 32'h3333_3ABC, 0, "R8");
        reg_write(4'h8, 32'h0000_8000);
        rd_miss(1, 32'h0080_3ABC, "R8");
        rd_hit(0, 32'h00C0_1234, 32'h4444_4234, 0, "R8");
        fill(1, 32'h0080_3000, 32'h3333_3011);
        reg_write(4'h8, 32'h0000_0000);
        rd_miss(0, 32'h00C0_1234, "R8");
        rd_hit(1, 32'h0080_3ABC, 32'h3333_3ABC, 0, "R8");

        // R9 pointer rewrites
        fill(0, 32'h00C0_1000, 32'h4444_4015);
        reg_write(4'h4, 32'h0000_0005);
        rd_miss(0, 32'h00C0_1234, "R9");
        rd_hit(1, 32'h0080_3ABC, 32'h3333_3ABC, 0, "R9");
        fill(0, 32'h00C0_1000, 32'h4444_4015);
        reg_write(4'h0, 32'h0000_0007);
        rd_miss(1, 32'h0080_3ABC, "R9");
        rd_hit(0, 32'h00C0_1234, 32'h4444_4234, 0, "R9");

        // R7 read of buffer control empties both
        fill(1, 32'h0080_3000, 32'h3333_3011);
        reg_read(4'h8, 32'h0, "R7");
        rd_miss(0, 32'h00C0_1234, "R7");
        rd_miss(1, 32'h0080_3ABC, "R7");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule